// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside an I2C master's bit engine and watches the shared data line while the local side holds the bus. Another master may drive the same line. When a bit that the local side releases high is found low on the bus, the block reports that arbitration was lost. It moves the controller into slave-receiver mode and tells the clock generator how to wind down.

There are two cases. A loss while transmitting happens in the middle of a byte: the monitor keeps SCL running until the last data bit of that byte has been clocked, then halts the clock. A loss while receiving can only occur on a not-acknowledge slot, which is already the end of the byte, so the clock halts at once. A sticky flag records every loss until the controlling state machine clears it. The clear also returns the monitor to master mode.

SDA is brought through a synchronizer and compared once per bit. The compare happens only in the cycle where the bit engine raises its SCL-high sample strobe. Data bits are numbered from DATA_BITS-1 down to 0, so index 0 is the last data bit of a byte. The acknowledge slot is flagged separately by `ackPhase`.

Top module: `bus_arb_monitor`

## Requirements
- R1: After reset, `arbLost`, `slaveRx`, `clkFinish`, `clkHalt` and `lossFlag` are all 0.
- R2: With `masterTx`=1 and `ackPhase`=0, a strobe that sees `driveBit`=1 while synchronized SDA is 0 raises `arbLost` for exactly one cycle, the cycle after the strobe. In that same cycle `slaveRx` and `lossFlag` go to 1.
- R3: In transmit mode, a strobe with `driveBit`=0 never causes a loss, whatever level SDA has.
- R4: SDA is compared only in a cycle where `sclHighStb`=1. SDA is sampled through SYNC_STAGES (default 2) flip-flops, so it must be stable for that many cycles before the strobe. A low SDA in cycles without a strobe has no effect.
- R5: After a transmit loss on a bit index above 0, `clkFinish`=1 and `clkHalt`=0. These hold until a strobe on bit index 0 with `ackPhase`=0. After that strobe, `clkFinish`=0 and `clkHalt`=1.
- R6: A transmit loss on bit index 0 goes straight to `clkHalt`=1 with `clkFinish`=0.
- R7: With `masterRx`=1 and `masterTx`=0, a strobe in the acknowledge slot (`ackPhase`=1) with `driveBit`=1 (not-acknowledge) and SDA low gives a loss. That loss raises `arbLost`, `slaveRx`, `lossFlag` and `clkHalt` at once, and `clkFinish` stays 0.
- R8: In receive mode, data-bit strobes and acknowledge slots where `driveBit`=0 never cause a loss.
- R9: In transmit mode, strobes in the acknowledge slot are not compared.
- R10: `lossFlag` stays 1 until `lossClr`=1 is sampled. That clear sets `lossFlag`, `slaveRx`, `clkFinish` and `clkHalt` to 0. If a loss and a clear are sampled in the same cycle, the loss wins.
- R11: Once a loss is recorded, further mismatches produce no new `arbLost` pulse until a clear.
- R12: With both `masterTx` and `masterRx` at 0, no compare takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterTx | input | 1 | Controller is master transmitter |
| masterRx | input | 1 | Controller is master receiver |
| ackPhase | input | 1 | Current bit is the acknowledge slot |
| bitIdx | input | $clog2(DATA_BITS) | Data bit index, counting down to 0 |
| driveBit | input | 1 | Level the controller drives on SDA (1 = released) |
| sdaIn | input | 1 | Raw SDA line level |
| sclHighStb | input | 1 | One-cycle strobe at the SCL-high sample point |
| lossClr | input | 1 | Clears the flag and returns to master mode |
| arbLost | output | 1 | One-cycle arbitration-lost pulse |
| slaveRx | output | 1 | Controller must act as slave receiver |
| clkFinish | output | 1 | Clock generator keeps clocking to byte end |
| clkHalt | output | 1 | Clock generator stops SCL pulses |
| lossFlag | output | 1 | Sticky arbitration-lost flag |

## Verification
The checker verifies the following on every cycle:
- `arbLost` is a single-cycle pulse.
- Every pulse follows a sample strobe and comes with slave mode and the sticky flag.
- `clkFinish` and `clkHalt` are never high together.
- The flag holds until it is cleared.
- A finishing clock hands over only to a halt.
- No second pulse appears while in slave mode.

Only the directed scenarios can show when a loss is correct:
- transmitted zeros and acknowledge slots are ignored;
- a mid-byte loss clocks out exactly to bit index 0;
- a not-acknowledge loss halts at once;
- set wins over clear when both are sampled together.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [1:0] {
    ST_MASTER = 2'd0,
    ST_FINISH = 2'd1,
    ST_HALT   = 2'd2
  } arbState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cmpEn;
    logic setFlag;
    logic clrFlag;
  } ctrlStb_t;

  // datapath -> control events
  typedef struct packed {
    logic txLoss;
    logic rxLoss;
    logic lastBit;
  } arbEvt_t;

endpackage

// File: rtl/bus_arb_datapath.sv
module bus_arb_datapath
  import bus_arb_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DATA_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterTx,
  input  logic             masterRx,
  input  logic             ackPhase,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             driveBit,
  input  logic             sdaIn,
  input  logic             sclHighStb,
  input  ctrlStb_t         stb,
  output arbEvt_t          evt,
  output logic             lossFlag
);

  logic sdaSmp;

  generate
    if (SYNC_STAGES < 2) begin : g_sync_one
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= sdaIn;
      end
      assign sdaSmp = syncQ;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdaIn};
      end
      assign sdaSmp = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  logic mismatch;
  logic rxActive;

  assign mismatch = sclHighStb && driveBit && !sdaSmp;
  assign rxActive = masterRx && !masterTx;

  always_comb begin
    evt.txLoss  = stb.cmpEn && masterTx && !ackPhase && mismatch;
    evt.rxLoss  = stb.cmpEn && rxActive && ackPhase && mismatch;
    evt.lastBit = sclHighStb && !ackPhase && (bitIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lossFlag <= 1'b0;
    else if (stb.setFlag)  lossFlag <= 1'b1;
    else if (stb.clrFlag)  lossFlag <= 1'b0;
  end

endmodule

// File: rtl/bus_arb_control.sv
module bus_arb_control
  import bus_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lossClr,
  input  arbEvt_t  evt,
  output ctrlStb_t stb,
  output logic     arbLost,
  output logic     slaveRx,
  output logic     clkFinish,
  output logic     clkHalt
);

  arbState_t state, stateNxt;
  logic      lossNow;

  assign lossNow = (state == ST_MASTER) && (evt.txLoss || evt.rxLoss);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_MASTER: begin
        if (evt.rxLoss)      stateNxt = ST_HALT;
        else if (evt.txLoss) stateNxt = evt.lastBit ? ST_HALT : ST_FINISH;
      end
      ST_FINISH: begin
        if (lossClr)          stateNxt = ST_MASTER;
        else if (evt.lastBit) stateNxt = ST_HALT;
      end
      ST_HALT: begin
        if (lossClr) stateNxt = ST_MASTER;
      end
      default: stateNxt = ST_MASTER;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_MASTER;
      arbLost <= 1'b0;
    end else begin
      state   <= stateNxt;
      arbLost <= lossNow;
    end
  end

  always_comb begin
    stb.cmpEn   = (state == ST_MASTER);
    stb.setFlag = lossNow;
    stb.clrFlag = lossClr;
  end

  assign slaveRx   = (state != ST_MASTER);
  assign clkFinish = (state == ST_FINISH);
  assign clkHalt   = (state == ST_HALT);

endmodule

// File: rtl/bus_arb_monitor.sv
module bus_arb_monitor
  import bus_arb_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DATA_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterTx,
  input  logic             masterRx,
  input  logic             ackPhase,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             driveBit,
  input  logic             sdaIn,
  input  logic             sclHighStb,
  input  logic             lossClr,
  output logic             arbLost,
  output logic             slaveRx,
  output logic             clkFinish,
  output logic             clkHalt,
  output logic             lossFlag
);

  ctrlStb_t stb;
  arbEvt_t  evt;

  bus_arb_datapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .masterTx  (masterTx),
    .masterRx  (masterRx),
    .ackPhase  (ackPhase),
    .bitIdx    (bitIdx),
    .driveBit  (driveBit),
    .sdaIn     (sdaIn),
    .sclHighStb(sclHighStb),
    .stb       (stb),
    .evt       (evt),
    .lossFlag  (lossFlag)
  );

  bus_arb_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .lossClr  (lossClr),
    .evt      (evt),
    .stb      (stb),
    .arbLost  (arbLost),
    .slaveRx  (slaveRx),
    .clkFinish(clkFinish),
    .clkHalt  (clkHalt)
  );

endmodule

// File: rtl/bus_arb_monitor_chk.sv
module bus_arb_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic sclHighStb,
  input logic lossClr,
  input logic arbLost,
  input logic slaveRx,
  input logic clkFinish,
  input logic clkHalt,
  input logic lossFlag
);

  // R2
  lost_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |=> !arbLost);

  // R2
  lost_sets_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> (slaveRx && lossFlag));

  // R4
  lost_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> $past(sclHighStb));

  // R5
  finish_then_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clkFinish) && !$past(lossClr)) |-> clkHalt);

  // R5
  finish_halt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(clkFinish && clkHalt));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && !lossClr) |=> lossFlag);

  // R11
  no_repeat_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveRx && !lossClr) |=> !arbLost);

endmodule

bind bus_arb_monitor bus_arb_monitor_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclHighStb(sclHighStb),
  .lossClr   (lossClr),
  .arbLost   (arbLost),
  .slaveRx   (slaveRx),
  .clkFinish (clkFinish),
  .clkHalt   (clkHalt),
  .lossFlag  (lossFlag)
);

// File: tb/bus_arb_monitor_bench.sv
module bus_arb_monitor_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterTx = 1'b0;
  logic       masterRx = 1'b0;
  logic       ackPhase = 1'b0;
  logic [2:0] bitIdx = 3'd7;
  logic       driveBit = 1'b1;
  logic       sdaIn = 1'b1;
  logic       sclHighStb = 1'b0;
  logic       lossClr = 1'b0;
  logic       arbLost, slaveRx, clkFinish, clkHalt, lossFlag;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_arb_monitor u_bus_arb_monitor (
    .clk(clk), .rstN(rstN), .masterTx(masterTx), .masterRx(masterRx),
    .ackPhase(ackPhase), .bitIdx(bitIdx), .driveBit(driveBit), .sdaIn(sdaIn),
    .sclHighStb(sclHighStb), .lossClr(lossClr), .arbLost(arbLost),
    .slaveRx(slaveRx), .clkFinish(clkFinish), .clkHalt(clkHalt),
    .lossFlag(lossFlag)
  );

  // observed vector {arbLost, slaveRx, clkFinish, clkHalt, lossFlag}
  task automatic expect5(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {arbLost, slaveRx, clkFinish, clkHalt, lossFlag};
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // present one bit, let SDA settle through the synchronizer, strobe once;
  // returns at the negedge right after the strobe edge
  task automatic strobeBit(logic drv, logic sda, logic [2:0] idx, logic ack);
    @(negedge clk);
    driveBit = drv; sdaIn = sda; bitIdx = idx; ackPhase = ack;
    repeat (3) @(negedge clk);
    sclHighStb = 1'b1;
    @(negedge clk);
    sclHighStb = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    lossClr = 1'b1;
    @(negedge clk);
    lossClr = 1'b0;
  endtask

  task automatic tResetState();
    expect5("R1 reset", 5'b00000);
  endtask

  task automatic tTxClean();
    logic [7:0] pattern = 8'hA5;
    masterTx = 1'b1; masterRx = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      strobeBit(pattern[i], pattern[i], 3'(i), 1'b0);
      expect5("R3 tx bus matches", 5'b00000);
    end
    strobeBit(1'b0, 1'b1, 3'd4, 1'b0);
    expect5("R3 driven zero, bus high", 5'b00000);
    strobeBit(1'b0, 1'b0, 3'd3, 1'b0);
    expect5("R3 driven zero, bus low", 5'b00000);
  endtask

  task automatic tNoStrobe();
    masterTx = 1'b1;
    @(negedge clk);
    driveBit = 1'b1; sdaIn = 1'b0; bitIdx = 3'd6; ackPhase = 1'b0;
    repeat (6) @(negedge clk);
    expect5("R4 low SDA without strobe", 5'b00000);
    sdaIn = 1'b1;
    repeat (3) @(negedge clk);
    sclHighStb = 1'b1;
    @(negedge clk);
    sclHighStb = 1'b0;
    expect5("R4 strobe after SDA recovered", 5'b00000);
  endtask

  task automatic tTxMidLoss();
    masterTx = 1'b1; masterRx = 1'b0;
    strobeBit(1'b1, 1'b0, 3'd5, 1'b0);
    expect5("R2 R5 loss mid byte", 5'b11101);
    @(negedge clk);
    expect5("R2 pulse single cycle", 5'b01101);
    for (int i = 4; i >= 1; i--) begin
      strobeBit(1'b1, 1'b0, 3'(i), 1'b0);
      expect5("R11 R5 keep clocking, no new pulse", 5'b01101);
    end
    strobeBit(1'b1, 1'b1, 3'd0, 1'b0);
    expect5("R5 halt after last bit", 5'b01011);
    repeat (3) @(negedge clk);
    expect5("R10 flag sticky", 5'b01011);
    doClear();
    expect5("R10 clear returns to master", 5'b00000);
  endtask

  task automatic tTxLastBitLoss();
    masterTx = 1'b1;
    strobeBit(1'b1, 1'b0, 3'd0, 1'b0);
    expect5("R6 loss on last bit", 5'b11011);
    doClear();
    expect5("R10 clear after R6", 5'b00000);
  endtask

  task automatic tTxAckIgnored();
    masterTx = 1'b1;
    strobeBit(1'b1, 1'b0, 3'd0, 1'b1);
    expect5("R9 tx ack slot not compared", 5'b00000);
  endtask

  task automatic tRx();
    masterTx = 1'b0; masterRx = 1'b1;
    strobeBit(1'b1, 1'b0, 3'd2, 1'b0);
    expect5("R8 rx data bit", 5'b00000);
    strobeBit(1'b0, 1'b0, 3'd0, 1'b1);
    expect5("R8 rx ack driven low", 5'b00000);
    strobeBit(1'b1, 1'b1, 3'd0, 1'b1);
    expect5("R7 nack seen high", 5'b00000);
    strobeBit(1'b1, 1'b0, 3'd0, 1'b1);
    expect5("R7 nack overruled", 5'b11011);
    doClear();
    expect5("R10 clear after R7", 5'b00000);
  endtask

  task automatic tNoMode();
    masterTx = 1'b0; masterRx = 1'b0;
    strobeBit(1'b1, 1'b0, 3'd3, 1'b0);
    expect5("R12 no mode data", 5'b00000);
    strobeBit(1'b1, 1'b0, 3'd0, 1'b1);
    expect5("R12 no mode ack", 5'b00000);
  endtask

  task automatic tSetBeatsClear();
    masterTx = 1'b0; masterRx = 1'b1;
    @(negedge clk);
    driveBit = 1'b1; sdaIn = 1'b0; bitIdx = 3'd0; ackPhase = 1'b1;
    repeat (3) @(negedge clk);
    sclHighStb = 1'b1; lossClr = 1'b1;
    @(negedge clk);
    sclHighStb = 1'b0; lossClr = 1'b0;
    expect5("R10 set wins over clear", 5'b11011);
    doClear();
    expect5("R10 final clear", 5'b00000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tTxClean();
    tNoStrobe();
    tTxMidLoss();
    tTxLastBitLoss();
    tTxAckIgnored();
    tRx();
    tNoMode();
    tSetBeatsClear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule